// File: doc/BRIEF.md
# Destination Address Filter

This block decides whether an incoming frame is meant for this station. Its input is the destination field one byte at a time, each byte tagged with its position 0 to 5. The last byte also carries the top six bits of the frame check sum running at that point. The filter compares the bytes against a programmed 48-bit station address. It checks whether every byte is all ones, which marks broadcast. It notes whether the first byte marks a group address, and if so it uses the six check-sum bits to look up one bit in a 64-bit group filter.

One clock after the last address byte is taken, the block raises a single-cycle decision strobe. An accept flag travels with the strobe. A plain write port loads the station address, the group filter and two enables. One enable gates broadcast acceptance and the other gates group acceptance. A receive path would use the strobe to keep or discard the frame it is collecting.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset the decision strobe and accept flag are low. The station address and the group filter are all zero, and both enables are off.
- R2: When all six bytes equal the programmed station bytes, the decision is accept. Station byte k is compared with the byte whose position is k, and position 0 arrives first.
- R3: If any single bit of any of the six bytes differs from the station address, and neither other path applies, the decision is reject.
- R4: An address is a group address when bit 0 of byte 0 is 1 and the address is not all ones. With the group enable on, such an address is accepted exactly when filter bit h is set. h is the six-bit hash value presented with byte 5.
- R5: With the group enable off, a group address is rejected for every hash value.
- R6: An all-ones address is accepted when the broadcast enable is on and rejected when it is off. It is never judged by the group filter.
- R7: The decision strobe goes high in the clock after byte 5 is taken and stays high for exactly one cycle.
- R8: Only the sequence 0,1,2,3,4,5 makes a decision. A byte at position 0 always starts a new address. Any other out-of-order position drops the address in progress, and no strobe follows.
- R9: Idle cycles between address bytes have no effect on the decision.
- R10: Write map: offsets 0 to 5 hold station bytes 0 to 5. Offsets 6 to 13 hold group filter bytes 0 to 7, and filter byte j bit b is filter bit 8j+b. Offset 14 is control, with bit 0 as the broadcast enable and bit 1 as the group enable. Writes to offset 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration write offset |
| wr_data | input | 8 | Configuration write data |
| byte_valid | input | 1 | An address byte is present |
| byte_idx | input | 3 | Position of the byte within the destination field |
| byte_data | input | 8 | Address byte |
| crc_hash | input | 6 | Top check-sum bits, sampled with byte 5 |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision result, meaningful with dec_valid |

## Verification
The bench flips every one of the 48 address bits in turn. A filter that ignores one byte lane or one bit would accept one of those frames. It sweeps all 64 hash values against a computed filter pattern, with the group enable on and off. A swapped filter byte order or bit order would then accept at the wrong indices. It sends an all-ones address with the group filter fully set and broadcast disabled, which catches a design that lets broadcast fall into the group path. Skipped positions, lone final bytes, restarts and idle gaps catch sequencing errors that would give spurious or missing strobes.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
    localparam int unsigned CTRL_BC_BIT = 0;
    localparam int unsigned CTRL_MC_BIT = 1;
    localparam logic [7:0] ALL_ONES_BYTE = 8'hFF;
endpackage

// File: rtl/afilt_regs.sv
module afilt_regs
    import afilt_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int FILTER_BITS = 64,
    parameter int WA_W        = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WA_W-1:0]         wr_addr,
    input  logic [7:0]              wr_data,
    output logic [ADDR_BYTES*8-1:0] station,
    output logic [FILTER_BITS-1:0]  filter,
    output logic                    bc_en,
    output logic                    mc_en
);
    localparam int FILT_BYTES = FILTER_BITS / 8;
    localparam int CTRL_OFS   = ADDR_BYTES + FILT_BYTES;

    typedef struct packed {
        logic [ADDR_BYTES*8-1:0] station;
        logic [FILTER_BITS-1:0]  filter;
        logic                    bc_en;
        logic                    mc_en;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (wr_addr == WA_W'(k)) rg_d.station[8*k +: 8] = wr_data;
            end
            for (int k = 0; k < FILT_BYTES; k++) begin
                if (wr_addr == WA_W'(ADDR_BYTES + k)) rg_d.filter[8*k +: 8] = wr_data;
            end
            if (wr_addr == WA_W'(CTRL_OFS)) begin
                rg_d.bc_en = wr_data[CTRL_BC_BIT];
                rg_d.mc_en = wr_data[CTRL_MC_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign station = rg_q.station;
    assign filter  = rg_q.filter;
    assign bc_en   = rg_q.bc_en;
    assign mc_en   = rg_q.mc_en;

    // R10: a control write lands in both enables on the next cycle
    p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == WA_W'(CTRL_OFS)) |=>
            (bc_en == $past(wr_data[CTRL_BC_BIT]) && mc_en == $past(wr_data[CTRL_MC_BIT])));

    // R10: without a write the configuration holds
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(station) && $stable(filter) && $stable(bc_en) && $stable(mc_en)));
endmodule

// File: rtl/afilt_bytecmp.sv
module afilt_bytecmp
    import afilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_BYTES*8-1:0] station,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              data,
    output logic                    eq,
    output logic                    ones,
    output logic                    grp
);
    localparam int LANES = 1 << IDX_W;

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < ADDR_BYTES) begin : g_real
            assign lane_eq[g] = (station[8*g +: 8] == data);
        end else begin : g_pad
            assign lane_eq[g] = 1'b0;
        end
    end

    assign eq   = lane_eq[idx];
    assign ones = (data == ALL_ONES_BYTE);
    assign grp  = data[0];
endmodule

// File: rtl/afilt_hash.sv
module afilt_hash #(
    parameter int FILTER_BITS = 64,
    parameter int HASH_W      = 6
) (
    input  logic [FILTER_BITS-1:0] filter,
    input  logic [HASH_W-1:0]      hash,
    output logic                   hit
);
    assign hit = filter[hash];
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import afilt_pkg::*;
#(
    parameter  int ADDR_BYTES  = 6,
    parameter  int FILTER_BITS = 64,
    localparam int HASH_W      = $clog2(FILTER_BITS),
    localparam int IDX_W       = $clog2(ADDR_BYTES),
    localparam int WA_W        = $clog2(ADDR_BYTES + FILTER_BITS / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              byte_valid,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic [7:0]        byte_data,
    input  logic [HASH_W-1:0] crc_hash,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic             in_pkt;
        logic [IDX_W-1:0] nxt;
        logic             uni_ok;
        logic             bc_ok;
        logic             grp;
        logic             dec_v;
        logic             dec_a;
    } filt_t;

    filt_t st_d, st_q;

    logic [ADDR_BYTES*8-1:0] station;
    logic [FILTER_BITS-1:0]  filter;
    logic                    bc_en, mc_en;
    logic                    lane_eq, lane_ones, lane_grp, hash_hit;
    logic                    take, restart;
    logic                    uni_n, bc_n, grp_n;

    afilt_regs #(.ADDR_BYTES(ADDR_BYTES), .FILTER_BITS(FILTER_BITS), .WA_W(WA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .station(station), .filter(filter), .bc_en(bc_en), .mc_en(mc_en)
    );

    afilt_bytecmp #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_cmp (
        .station(station), .idx(byte_idx), .data(byte_data),
        .eq(lane_eq), .ones(lane_ones), .grp(lane_grp)
    );

    afilt_hash #(.FILTER_BITS(FILTER_BITS), .HASH_W(HASH_W)) u_hash (
        .filter(filter), .hash(crc_hash), .hit(hash_hit)
    );

    assign restart = byte_valid && (byte_idx == '0);
    assign take    = restart || (byte_valid && st_q.in_pkt && byte_idx == st_q.nxt);

    always_comb begin
        st_d       = st_q;
        st_d.dec_v = 1'b0;
        st_d.dec_a = 1'b0;
        uni_n      = restart ? lane_eq   : (st_q.uni_ok && lane_eq);
        bc_n       = restart ? lane_ones : (st_q.bc_ok && lane_ones);
        grp_n      = restart ? lane_grp  : st_q.grp;
        if (take) begin
            st_d.uni_ok = uni_n;
            st_d.bc_ok  = bc_n;
            st_d.grp    = grp_n;
            if (byte_idx == LAST_IDX) begin
                st_d.in_pkt = 1'b0;
                st_d.nxt    = '0;
                st_d.dec_v  = 1'b1;
                st_d.dec_a  = uni_n
                            || (bc_n && bc_en)
                            || (grp_n && !bc_n && mc_en && hash_hit);
            end else begin
                st_d.in_pkt = 1'b1;
                st_d.nxt    = byte_idx + 1'b1;
            end
        end else if (byte_valid) begin
            st_d.in_pkt = 1'b0;
            st_d.nxt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_valid  = st_q.dec_v;
    assign dec_accept = st_q.dec_a;

    // R7: the strobe never lasts two cycles
    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R7: a strobe is always preceded by a final-position byte
    p_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(byte_valid && byte_idx == LAST_IDX));

    // R2: accept only appears together with the strobe
    p_accept_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    // R8: a final byte outside a running sequence gives no strobe
    p_no_orphan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_idx == LAST_IDX && !(st_q.in_pkt && st_q.nxt == LAST_IDX))
            |=> !dec_valid);

    // R8: an out-of-order byte drops the address in progress
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_idx != '0 && !(st_q.in_pkt && byte_idx == st_q.nxt))
            |=> !st_q.in_pkt);

    // R9: idle cycles leave the sequence position untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> ($stable(st_q.in_pkt) && $stable(st_q.nxt)));
endmodule

// File: tb/dst_addr_filter_bench.sv
`timescale 1ns/1ps
module dst_addr_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       byte_valid = 1'b0;
    logic [2:0] byte_idx = '0;
    logic [7:0] byte_data = '0;
    logic [5:0] crc_hash = '0;
    logic       dec_valid, dec_accept;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [47:0] STN   = 48'h6E_D5_4C_B3_1A_02;
    localparam logic [47:0] GRP   = 48'h00_00_5E_00_01_01;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

    always #2.5 clk = ~clk;

    dst_addr_filter u_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .byte_valid(byte_valid), .byte_idx(byte_idx), .byte_data(byte_data),
        .crc_hash(crc_hash), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic bit fbit(input int h);
        return ((h * 7 + 3) % 5) == 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_byte(input logic [2:0] i, input logic [7:0] d, input logic [5:0] h);
        byte_valid = 1'b1; byte_idx = i; byte_data = d; crc_hash = h;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    // sends positions 0..5 of a, optional idle gap after each byte, then checks
    task automatic run_pkt(input string req, input logic [47:0] a, input logic [5:0] h,
                           input int gap, input bit exp_a);
        for (int k = 0; k < 6; k++) begin
            put_byte(3'(k), a[8*k +: 8], h);
            if (k < 5) repeat (gap) @(negedge clk);
        end
        chk(req, int'(dec_valid), 1);
        chk(req, int'(dec_accept), int'(exp_a));
        @(negedge clk);
        chk({req, " strobe width R7"}, int'(dec_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 dec_valid", int'(dec_valid), 0);
        chk("R1 dec_accept", int'(dec_accept), 0);
        run_pkt("R1 zero station unprogrammed", 48'h0, 6'd0, 0, 1'b1);
        run_pkt("R1 broadcast disabled at reset", BCAST, 6'd0, 0, 1'b0);

        // R10: program station, filter, control
        for (int k = 0; k < 6; k++) cfg_write(4'(k), STN[8*k +: 8]);
        for (int j = 0; j < 8; j++) begin
            logic [7:0] fb;
            for (int b = 0; b < 8; b++) fb[b] = fbit(8*j + b);
            cfg_write(4'(6 + j), fb);
        end
        cfg_write(4'd14, 8'h00);

        // R2: exact match
        run_pkt("R2 exact match", STN, 6'd0, 0, 1'b1);

        // R3: every single-bit error rejected
        for (int bit_i = 0; bit_i < 48; bit_i++) begin
            logic [47:0] a;
            a = STN;
            a[bit_i] = ~a[bit_i];
            run_pkt("R3 bit flip", a, 6'd0, 0, 1'b0);
        end

        // R4: group filter sweep
        cfg_write(4'd14, 8'h02);
        for (int h = 0; h < 64; h++) run_pkt("R4 hash lookup", GRP, 6'(h), 0, fbit(h));
        run_pkt("R4 unicast still accepted", STN, 6'd1, 0, 1'b1);

        // R5: group enable off
        cfg_write(4'd14, 8'h00);
        for (int h = 0; h < 64; h++) run_pkt("R5 group disabled", GRP, 6'(h), 0, 1'b0);

        // R6: broadcast
        cfg_write(4'd14, 8'h01);
        run_pkt("R6 broadcast enabled", BCAST, 6'd1, 0, 1'b1);
        for (int j = 0; j < 8; j++) cfg_write(4'(6 + j), 8'hFF);
        cfg_write(4'd14, 8'h02);
        run_pkt("R6 broadcast not via group path", BCAST, 6'd5, 0, 1'b0);
        run_pkt("R6 group with full filter", GRP, 6'd5, 0, 1'b1);

        // R10: unmapped write changes nothing
        cfg_write(4'd15, 8'hFF);
        run_pkt("R10 unmapped write, broadcast still off", BCAST, 6'd5, 0, 1'b0);
        run_pkt("R10 unmapped write, station kept", STN, 6'd0, 0, 1'b1);
        cfg_write(4'd14, 8'h00);

        // R8: skipped position
        put_byte(3'd0, STN[7:0], 6'd0);
        put_byte(3'd1, STN[15:8], 6'd0);
        put_byte(3'd3, STN[31:24], 6'd0);
        put_byte(3'd4, STN[39:32], 6'd0);
        put_byte(3'd5, STN[47:40], 6'd0);
        chk("R8 skipped position no strobe", int'(dec_valid), 0);
        @(negedge clk);
        chk("R8 skipped position no strobe later", int'(dec_valid), 0);
        // R8: lone final byte
        put_byte(3'd5, STN[47:40], 6'd0);
        chk("R8 lone final byte", int'(dec_valid), 0);
        // R8: out-of-range position aborts
        put_byte(3'd0, STN[7:0], 6'd0);
        put_byte(3'd1, STN[15:8], 6'd0);
        put_byte(3'd7, 8'h00, 6'd0);
        put_byte(3'd2, STN[23:16], 6'd0);
        put_byte(3'd3, STN[31:24], 6'd0);
        put_byte(3'd4, STN[39:32], 6'd0);
        put_byte(3'd5, STN[47:40], 6'd0);
        chk("R8 position 7 aborts", int'(dec_valid), 0);
        // R8: restart mid-address
        put_byte(3'd0, 8'h55, 6'd0);
        put_byte(3'd1, 8'h66, 6'd0);
        put_byte(3'd2, 8'h77, 6'd0);
        run_pkt("R8 restart on position 0", STN, 6'd0, 0, 1'b1);

        // R9: idle gaps
        for (int g = 1; g < 4; g++) run_pkt("R9 gaps match", STN, 6'd0, g, 1'b1);
        begin
            logic [47:0] a;
            a = STN;
            a[44] = ~a[44];
            run_pkt("R9 gaps mismatch", a, 6'd0, 2, 1'b0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule